// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Sequencer

This block is the host side of a link to a small three-wire serial EEPROM. A client presents one request at a time: an operation code, an 8-bit address and an 8-bit data byte. The sequencer turns the request into a bit-serial frame. It drives a select line, a serial clock and an outgoing data line, and it samples the device's return line. For a read it strips the leading zero the device sends before the data and returns the byte. For the four programming operations it drops select for the minimum gap, raises it again, and watches the return line until the device reports ready.

The serial clock is derived from the system clock, and each phase lasts `HALF_CYC` cycles. The select gap, the interval between status samples and the maximum number of status samples are all parameters. The `busy` output is high from acceptance to completion. `done` pulses once per operation, and `err` pulses with it when polling gave up.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, `ser_sel`, `ser_clk`, `ser_mosi`, `busy`, `done` and `err` are all low.
- R2: A request is taken only while `busy` is low. `busy` then stays high until the cycle `done` pulses, and `ser_sel` stays low whenever `busy` is low. A request raised while busy starts no frame and has no effect on the device.
- R3: Each frame sends a 1 start bit, then a 2-bit opcode, then a 9-bit address field made of a 0 followed by the address MSB first. Request codes and opcodes are: 0 read (opcode 10), 1 write (01), 2 erase (11). Codes 3 erase-all, 4 write-all, 5 enable and 6 disable use opcode 00, with the top two address-field bits set to 10, 01, 11 and 00 respectively and the other field bits at 0.
- R4: Erase, erase-all, enable and disable frames have 12 clock pulses. Read, write and write-all frames have 20, and the write data follows the address MSB first.
- R5: `ser_clk` rises and falls only while `ser_sel` is high. Every low and high phase inside a frame lasts exactly `HALF_CYC` cycles. `ser_mosi` does not change while `ser_clk` is high.
- R6: On a read, the line is sampled at the end of each low phase, including one extra low phase after the last pulse. `rdata` holds the 8 bits that follow the dummy zero, MSB first, from the cycle `done` pulses.
- R7: `ser_sel` stays low for at least `CSL_CYC` cycles before every rise.
- R8: After a programming frame (write, erase, erase-all, write-all), select is raised again after the gap. The return line is sampled every `POLL_WAIT` cycles, and select falls at the first sample that reads 1.
- R9: If `POLL_LIMIT` samples all read 0, select falls and `err` pulses together with `done`.
- R10: `done` is a one-cycle pulse, and `err` is never high without `done`.
- R11: Read, enable and disable raise select exactly once per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 3 | Operation code (R3) |
| req_addr | input | AW | Target address |
| req_wdata | input | DW | Data for write and write-all |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Polling limit reached, valid with done |
| rdata | output | DW | Last read result |
| ser_sel | output | 1 | Device select |
| ser_clk | output | 1 | Serial clock |
| ser_mosi | output | 1 | Serial data to the device |
| ser_miso | input | 1 | Serial data and status from the device |

## Verification
The hardest situation to reach from the ports is the polling limit. A healthy device always turns ready, so the timeout path never runs on its own. The bench's device model has a stuck-busy switch that holds its status at 0, and a write issued with that switch set must end after exactly `POLL_LIMIT*POLL_WAIT` cycles of select high, with `err` set. A second hard case is the request raised while busy. The bench pulses `req_valid` with a destructive erase-all in the middle of an enable frame, then confirms that only one frame reached the model and that a read-back is unchanged.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WRAL  = 3'd4,
    OP_EWEN  = 3'd5,
    OP_EWDS  = 3'd6
  } mw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } mw_state_e;

endpackage

// File: rtl/mwc_timer.sv
module mwc_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  // Fires load_val cycles after the load edge.
  assign expire = (cnt == TW'(1));
endmodule

// File: rtl/mwc_frame_gen.sv
module mwc_frame_gen
  import mwc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int FL = 4 + AW + DW,
  parameter int LW = $clog2(FL + 1)
) (
  input  logic [2:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [FL-1:0] frame,
  output logic [LW-1:0] len,
  output logic          is_prog,
  output logic          is_read
);
  localparam int HDR = 4 + AW;

  always_comb begin
    frame   = '0;
    len     = LW'(HDR);
    is_prog = 1'b0;
    is_read = 1'b0;
    case (mw_op_e'(op))
      OP_READ: begin
        frame   = {3'b110, 1'b0, addr, {DW{1'b0}}};
        len     = LW'(FL);
        is_read = 1'b1;
      end
      OP_WRITE: begin
        frame   = {3'b101, 1'b0, addr, wdata};
        len     = LW'(FL);
        is_prog = 1'b1;
      end
      OP_ERASE: begin
        frame   = {3'b111, 1'b0, addr, {DW{1'b0}}};
        is_prog = 1'b1;
      end
      OP_ERAL: begin
        frame   = {3'b100, 2'b10, {(AW-1){1'b0}}, {DW{1'b0}}};
        is_prog = 1'b1;
      end
      OP_WRAL: begin
        frame   = {3'b100, 2'b01, {(AW-1){1'b0}}, wdata};
        len     = LW'(FL);
        is_prog = 1'b1;
      end
      OP_EWEN: frame = {3'b100, 2'b11, {(AW-1){1'b0}}, {DW{1'b0}}};
      default: frame = {3'b100, 2'b00, {(AW-1){1'b0}}, {DW{1'b0}}};
    endcase
  end
endmodule

// File: rtl/mwc_rx_shift.sv
module mwc_rx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift,
  input  logic          din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= {q[DW-2:0], din};
  end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mwc_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int HALF_CYC   = 13,
  parameter int CSL_CYC    = 13,
  parameter int POLL_WAIT  = 26,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          ser_sel,
  output logic          ser_clk,
  output logic          ser_mosi,
  input  logic          ser_miso
);
  localparam int HDR   = 4 + AW;
  localparam int FL    = HDR + DW;
  localparam int LW    = $clog2(FL + 1);
  localparam int TM1   = (HALF_CYC > CSL_CYC) ? HALF_CYC : CSL_CYC;
  localparam int TMAX  = (TM1 > POLL_WAIT) ? TM1 : POLL_WAIT;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PCW   = $clog2(POLL_LIMIT + 1);

  mw_state_e     state;
  logic [FL-1:0] frame_q;
  logic [LW-1:0] len_q, bit_idx;
  logic          prog_q, read_q, phase_hi, polled, err_pend;
  logic [PCW-1:0] poll_cnt;

  logic [FL-1:0] fg_frame;
  logic [LW-1:0] fg_len;
  logic          fg_prog, fg_read;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic [DW-1:0] rx_q;
  logic          rx_shift;
  logic          last_poll;

  mwc_frame_gen #(.AW(AW), .DW(DW), .FL(FL), .LW(LW)) u_fgen (
    .op(req_op), .addr(req_addr), .wdata(req_wdata),
    .frame(fg_frame), .len(fg_len), .is_prog(fg_prog), .is_read(fg_read)
  );

  mwc_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(tmr_exp)
  );

  assign rx_shift = (state == ST_SHIFT) && tmr_exp && !phase_hi;

  mwc_rx_shift #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .shift(rx_shift), .din(ser_miso), .q(rx_q)
  );

  assign last_poll = (poll_cnt == PCW'(POLL_LIMIT - 1));

  // Timer reload decisions, mirroring the state register below.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(HALF_CYC);
    case (state)
      ST_IDLE: tmr_load = req_valid;
      ST_SHIFT: begin
        tmr_load = tmr_exp;
        if (!phase_hi && (bit_idx == len_q)) tmr_val = TW'(CSL_CYC);
      end
      ST_GAP: begin
        tmr_load = tmr_exp && prog_q && !polled;
        tmr_val  = TW'(POLL_WAIT);
      end
      ST_POLL: begin
        tmr_load = tmr_exp;
        tmr_val  = (ser_miso || last_poll) ? TW'(CSL_CYC) : TW'(POLL_WAIT);
      end
      default: tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      frame_q  <= '0;
      len_q    <= '0;
      bit_idx  <= '0;
      prog_q   <= 1'b0;
      read_q   <= 1'b0;
      phase_hi <= 1'b0;
      polled   <= 1'b0;
      err_pend <= 1'b0;
      poll_cnt <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
      ser_sel  <= 1'b0;
      ser_clk  <= 1'b0;
      ser_mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            frame_q  <= fg_frame;
            len_q    <= fg_len;
            prog_q   <= fg_prog;
            read_q   <= fg_read;
            bit_idx  <= '0;
            phase_hi <= 1'b0;
            polled   <= 1'b0;
            err_pend <= 1'b0;
            busy     <= 1'b1;
            ser_sel  <= 1'b1;
            ser_clk  <= 1'b0;
            ser_mosi <= fg_frame[FL-1];
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tmr_exp) begin
            if (!phase_hi) begin
              if (bit_idx == len_q) begin
                ser_sel  <= 1'b0;
                ser_mosi <= 1'b0;
                state    <= ST_GAP;
              end else begin
                ser_clk  <= 1'b1;
                phase_hi <= 1'b1;
              end
            end else begin
              ser_clk  <= 1'b0;
              phase_hi <= 1'b0;
              bit_idx  <= bit_idx + LW'(1);
              frame_q  <= frame_q << 1;
              ser_mosi <= frame_q[FL-2];
            end
          end
        end
        ST_GAP: begin
          if (tmr_exp) begin
            if (prog_q && !polled) begin
              ser_sel  <= 1'b1;
              poll_cnt <= '0;
              state    <= ST_POLL;
            end else begin
              done  <= 1'b1;
              err   <= err_pend;
              busy  <= 1'b0;
              if (read_q) rdata <= rx_q;
              state <= ST_IDLE;
            end
          end
        end
        ST_POLL: begin
          if (tmr_exp) begin
            if (ser_miso || last_poll) begin
              err_pend <= !ser_miso;
              ser_sel  <= 1'b0;
              polled   <= 1'b1;
              state    <= ST_GAP;
            end else begin
              poll_cnt <= poll_cnt + PCW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwc_checker.sv
module mwc_checker #(
  parameter int HALF_CYC = 13,
  parameter int CSL_CYC  = 13
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic ser_sel,
  input logic ser_clk,
  input logic ser_mosi
);
  localparam int MX = (HALF_CYC > CSL_CYC) ? HALF_CYC : CSL_CYC;
  localparam int CW = $clog2(MX + 2);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] sk_lo, sk_hi, sel_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_lo  <= SAT;
      sk_hi  <= '0;
      sel_lo <= SAT;
    end else begin
      sk_lo  <= ser_clk ? '0 : ((sk_lo == SAT) ? SAT : sk_lo + 1'b1);
      sk_hi  <= !ser_clk ? '0 : ((sk_hi == SAT) ? SAT : sk_hi + 1'b1);
      sel_lo <= ser_sel ? '0 : ((sel_lo == SAT) ? SAT : sel_lo + 1'b1);
    end
  end

  p_sk_low_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> (sk_lo >= CW'(HALF_CYC)));
  p_sk_high_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |-> (sk_hi >= CW'(HALF_CYC)));
  p_sk_needs_sel_r5: assert property (@(posedge clk) disable iff (rst)
    !ser_sel |-> !ser_clk);
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_mosi));
  p_sel_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_sel) |-> (sel_lo >= CW'(CSL_CYC)));
  p_idle_deselected_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ser_sel);
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
endmodule

bind mw_eeprom_ctrl mwc_checker #(.HALF_CYC(HALF_CYC), .CSL_CYC(CSL_CYC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .ser_sel(ser_sel), .ser_clk(ser_clk), .ser_mosi(ser_mosi)
);

// File: tb/mw_eeprom_ctrl_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_tb_top;
  localparam int HALF = 13;
  localparam int CSL  = 13;
  localparam int PW   = 26;
  localparam int PL   = 64;
  localparam int BUSY_T = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic busy, done, err, ser_sel, ser_clk, ser_mosi, ser_miso;
  logic [7:0] rdata;

  always #10 clk = ~clk;

  mw_eeprom_ctrl #(.AW(8), .DW(8), .HALF_CYC(HALF), .CSL_CYC(CSL),
                   .POLL_WAIT(PW), .POLL_LIMIT(PL)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .ser_sel(ser_sel), .ser_clk(ser_clk),
    .ser_mosi(ser_mosi), .ser_miso(ser_miso)
  );

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem [256];
  logic       en = 1'b0, stuck = 1'b0, reading = 1'b0, sk_m = 1'b0, miso_r = 1'b1;
  logic [7:0] raddr = '0;
  int         busy_cnt = 0, rcnt = 0, frames = 0, last_len = 0;
  logic [18:0] sh = '0, last_bits = '0;
  int          r;
  logic [18:0] nsh;

  assign ser_miso = ser_sel ? miso_r : 1'b1;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    sk_m <= ser_clk;
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (!ser_sel) begin
      if (rcnt != 0) begin
        frames    <= frames + 1;
        last_len  <= rcnt;
        last_bits <= sh;
      end
      rcnt <= 0; reading <= 1'b0; miso_r <= 1'b1;
    end else if (ser_clk && !sk_m) begin
      if (rcnt == 0) begin
        if (ser_mosi) begin rcnt <= 1; sh <= '0; end
      end else begin
        r = rcnt + 1;
        nsh = {sh[17:0], ser_mosi};
        rcnt <= r; sh <= nsh;
        if (r == 12) begin
          case (nsh[10:9])
            2'b10: begin reading <= 1'b1; raddr <= nsh[7:0]; miso_r <= 1'b0; end
            2'b11: if (en) begin mem[nsh[7:0]] <= 8'hFF; busy_cnt <= BUSY_T; end
            2'b00: case (nsh[8:7])
                     2'b11: en <= 1'b1;
                     2'b00: en <= 1'b0;
                     2'b10: if (en) begin
                              for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
                              busy_cnt <= BUSY_T;
                            end
                     default: ;
                   endcase
            default: ;
          endcase
        end
        if (reading && r >= 13 && r <= 20) miso_r <= mem[raddr][20 - r];
        if (r == 20 && en) begin
          if (nsh[18:17] == 2'b01) begin
            mem[nsh[15:8]] <= nsh[7:0]; busy_cnt <= BUSY_T;
          end else if (nsh[18:17] == 2'b00 && nsh[16:15] == 2'b01) begin
            for (int i = 0; i < 256; i++) mem[i] <= nsh[7:0];
            busy_cnt <= BUSY_T;
          end
        end
      end
    end else if (!reading) begin
      miso_r <= (busy_cnt != 0 || stuck) ? 1'b0 : 1'b1;
    end
  end

  // ---------------- line monitors ----------------
  logic sk_q = 1'b0, sel_q = 1'b0, mosi_q = 1'b0;
  int lo_run = 0, hi_run = 0, sel_lo_run = 1000, sel_hi_run = 0, last_hi = 0;
  int sel_rises = 0, bad_phase = 0, bad_mosi = 0, bad_gap = 0, bad_sk = 0;
  int done_cycles = 0, err_alone = 0;

  always @(posedge clk) begin
    if (!rst) begin
      sk_q <= ser_clk; sel_q <= ser_sel; mosi_q <= ser_mosi;
      lo_run <= (ser_sel && !ser_clk) ? lo_run + 1 : 0;
      hi_run <= (ser_sel && ser_clk) ? hi_run + 1 : 0;
      if (ser_clk && !sk_q && lo_run != HALF) bad_phase <= bad_phase + 1;
      if (!ser_clk && sk_q && ser_sel && hi_run != HALF) bad_phase <= bad_phase + 1;
      if (ser_clk && sk_q && ser_mosi != mosi_q) bad_mosi <= bad_mosi + 1;
      if (ser_clk && !ser_sel) bad_sk <= bad_sk + 1;
      sel_lo_run <= ser_sel ? 0 : sel_lo_run + 1;
      if (ser_sel && !sel_q) begin
        sel_rises <= sel_rises + 1;
        if (sel_lo_run < CSL) bad_gap <= bad_gap + 1;
      end
      sel_hi_run <= ser_sel ? sel_hi_run + 1 : 0;
      if (!ser_sel && sel_q) last_hi <= sel_hi_run;
      if (done) done_cycles <= done_cycles + 1;
      if (err && !done) err_alone <= err_alone + 1;
    end
  end

  // ---------------- request driver ----------------
  int n_ops = 0;
  logic [7:0] o_rdata;
  logic o_err;
  int o_rises, o_frames;

  task automatic do_op(input int op, input int a, input int d);
    int s_r, s_f, t;
    @(negedge clk);
    while (busy) @(negedge clk);
    s_r = sel_rises; s_f = frames;
    req_valid = 1'b1; req_op = 3'(op); req_addr = 8'(a); req_wdata = 8'(d);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    n_ops++;
    chk(done == 1'b1, "R2 done seen", int'(done), 1);
    o_rdata = rdata; o_err = err;
    o_rises = sel_rises - s_r; o_frames = frames - s_f;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!ser_sel && !ser_clk && !ser_mosi, "R1 lines low",
        {ser_sel, ser_clk, ser_mosi}, 0);
    chk(!busy && !done && !err, "R1 status low", {busy, done, err}, 0);
  endtask

  task automatic t_read;
    do_op(0, 8'h3C, 0);
    chk(o_rdata == 8'h66, "R6 read data", o_rdata, 8'h66);
    chk(last_len == 20, "R4 read length", last_len, 20);
    chk(last_bits[18:17] == 2'b10, "R3 read opcode", last_bits[18:17], 2);
    chk(last_bits[16:8] == 9'h03C, "R3 read address field", last_bits[16:8], 9'h03C);
    chk(o_rises == 1, "R11 read single select", o_rises, 1);
    chk(!o_err, "R9 read no error", o_err, 0);
  endtask

  task automatic t_write_locked;
    do_op(1, 8'h10, 8'hA5);
    chk(last_len == 20, "R4 write length", last_len, 20);
    chk(last_bits[18:17] == 2'b01, "R3 write opcode", last_bits[18:17], 1);
    chk(last_bits[7:0] == 8'hA5, "R4 write data MSB first", last_bits[7:0], 8'hA5);
    chk(o_rises == 2, "R8 select re-raised", o_rises, 2);
    chk(last_hi == PW, "R8 one poll when ready", last_hi, PW);
    do_op(0, 8'h10, 0);
    chk(o_rdata == 8'h4A, "R3 locked write ignored", o_rdata, 8'h4A);
  endtask

  task automatic t_enable;
    do_op(5, 0, 0);
    chk(last_len == 12, "R4 enable length", last_len, 12);
    chk(last_bits[10:7] == 4'b0011, "R3 enable code", last_bits[10:7], 3);
    chk(o_rises == 1, "R11 enable no poll", o_rises, 1);
  endtask

  task automatic t_write;
    do_op(1, 8'h10, 8'hC3);
    chk(last_hi > PW && (last_hi % PW) == 0, "R8 repeated polls", last_hi, PW);
    chk(!o_err, "R8 ready no error", o_err, 0);
    do_op(0, 8'h10, 0);
    chk(o_rdata == 8'hC3, "R6 read after write", o_rdata, 8'hC3);
  endtask

  task automatic t_erase;
    do_op(2, 8'h10, 0);
    chk(last_len == 12, "R4 erase length", last_len, 12);
    chk(last_bits[10:9] == 2'b11, "R3 erase opcode", last_bits[10:9], 3);
    do_op(0, 8'h10, 0);
    chk(o_rdata == 8'hFF, "R3 erase result", o_rdata, 8'hFF);
  endtask

  task automatic t_wral;
    do_op(4, 0, 8'h77);
    chk(last_len == 20, "R4 write-all length", last_len, 20);
    chk(last_bits[18:15] == 4'b0001, "R3 write-all code", last_bits[18:15], 1);
    do_op(0, 8'hFF, 0);
    chk(o_rdata == 8'h77, "R4 write-all data", o_rdata, 8'h77);
  endtask

  task automatic t_eral;
    do_op(3, 0, 0);
    chk(last_len == 12 && last_bits[10:7] == 4'b0010, "R3 erase-all code",
        last_bits[10:7], 2);
    do_op(0, 8'h80, 0);
    chk(o_rdata == 8'hFF, "R3 erase-all result", o_rdata, 8'hFF);
  endtask

  task automatic t_timeout;
    stuck = 1'b1;
    do_op(1, 8'h20, 8'h11);
    chk(o_err == 1'b1, "R9 error on limit", o_err, 1);
    chk(last_hi == PL * PW, "R9 poll window", last_hi, PL * PW);
    stuck = 1'b0;
  endtask

  task automatic t_busy_ignore;
    int s_f, t;
    @(negedge clk);
    while (busy) @(negedge clk);
    s_f = frames;
    req_valid = 1'b1; req_op = 3'd5; @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R2 busy during frame", busy, 1);
    req_valid = 1'b1; req_op = 3'd3; @(negedge clk); req_valid = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    n_ops++;
    repeat (100) @(negedge clk);
    chk(!busy && !ser_sel, "R2 idle after ignored request", {busy, ser_sel}, 0);
    chk(frames - s_f == 1, "R2 single frame", frames - s_f, 1);
    do_op(0, 8'h45, 0);
    chk(o_rdata == 8'hFF, "R2 ignored erase-all had no effect", o_rdata, 8'hFF);
  endtask

  task automatic t_disable;
    do_op(6, 0, 0);
    chk(last_len == 12 && last_bits[10:7] == 4'b0000, "R3 disable code",
        last_bits[10:7], 0);
    do_op(1, 8'h30, 8'h99);
    do_op(0, 8'h30, 0);
    chk(o_rdata == 8'hFF, "R3 write after disable ignored", o_rdata, 8'hFF);
  endtask

  task automatic t_monitors;
    chk(bad_phase == 0, "R5 phase lengths", bad_phase, 0);
    chk(bad_mosi == 0, "R5 data stable while clock high", bad_mosi, 0);
    chk(bad_sk == 0, "R5 clock only when selected", bad_sk, 0);
    chk(bad_gap == 0, "R7 select gap", bad_gap, 0);
    chk(done_cycles == n_ops, "R10 one done cycle per op", done_cycles, n_ops);
    chk(err_alone == 0, "R10 err only with done", err_alone, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_write_locked();
    t_enable();
    t_write();
    t_erase();
    t_wral();
    t_eral();
    t_timeout();
    t_busy_ignore();
    t_disable();
    t_monitors();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end
endmodule